// File: doc/BRIEF.md
# USB Full-Speed Frame Timer

This block times full-speed USB frames for a host controller from a 12 MHz counter clock. Each frame lasts a base count of 11936 clock periods plus a 7-bit adjust value, so software can trim the frame from 11936 to 12063 periods. This corrects for the error of the clock source or keeps the bus in step with system time. A one-cycle start-of-frame strobe marks each frame boundary. The strobe is what the packet serializer and the schedule engine act on.

A 10-bit frame number advances at every boundary. It is joined with a 4 KB-aligned base register to form the word address of the current entry in a 1024-entry frame list in memory. Software reaches the adjust register and the base register through a one-word write/read port. An adjust value written in the middle of a frame does not alter that frame. It is used from the next boundary on.

Top module: `usb_frame_timer`

## Requirements
- R1: After `rst_ni` is asserted the adjust register holds decimal 64. Reading with `reg_sel_i`=0 returns 32'h0000_0040, which gives a frame of BASE_LEN+64 cycles (12000 by default).
- R2: A write with `reg_sel_i`=0 stores `reg_wdata_i[6:0]` and ignores all higher bits, including bit 7. A read with `reg_sel_i`=0 returns the stored value in bits 6:0 with bits 31:7 zero.
- R3: While `run_i` is high, `sof_o` is a single-cycle pulse. It rises once every BASE_LEN + active-adjust cycles and appears in the last cycle of each frame.
- R4: A new adjust value never changes the frame in progress. It becomes the active length only at the next frame boundary, or while `run_i` is low.
- R5: `hc_rst_i` high at a clock edge returns the adjust register and the active length to 64, and clears the cycle counter and the frame number. The base register is left unchanged.
- R6: `frame_num_o` increments by one in the cycle after each `sof_o` pulse, wraps from 1023 to 0, and is otherwise stable.
- R7: `entry_addr_o` equals {base[31:12], frame_num_o[9:0], 2'b00}, so its two low bits are always zero.
- R8: A write with `reg_sel_i`=1 stores only `reg_wdata_i[31:12]`. A read with `reg_sel_i`=1 returns those bits with bits 11:0 zero. The base register resets to zero.
- R9: While `run_i` is low the cycle counter holds at zero and no `sof_o` is produced. When `run_i` rises, a full frame of the current length follows before the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 12 MHz frame counter clock |
| rst_ni | input | 1 | Global asynchronous reset, active low |
| hc_rst_i | input | 1 | Synchronous host-controller reset |
| run_i | input | 1 | Enables frame counting |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 adjust, 1 list base |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| sof_o | output | 1 | Start-of-frame strobe |
| frame_num_o | output | 10 | Current frame number |
| entry_addr_o | output | 32 | Word address of the current frame-list entry |

## Verification
A register write is visible on `reg_rdata_o` one clock after the write edge. The read path has no register, so a change of `reg_sel_i` shows in the same cycle. `sof_o` is decoded from the cycle counter and is due in the last cycle of a frame. `frame_num_o` and `entry_addr_o` change one clock after the strobe. A new adjust value first changes the distance to the strobe after the one that follows the write. The bench models each register as an integer that it updates on the rising edge. It compares every output on the falling edge of the same cycle, before it drives new inputs, so every expected value is read exactly where these latencies place it.

// File: rtl/usb_frame_timer_pkg.sv
package usb_frame_timer_pkg;
  typedef enum logic {
    SEL_ADJ  = 1'b0,
    SEL_BASE = 1'b1
  } reg_sel_e;

  localparam int unsigned DEF_BASE_LEN = 11936;
  localparam int unsigned DEF_ADJ_W    = 7;
  localparam int unsigned DEF_ADJ_RST  = 64;
  localparam int unsigned DEF_FN_W     = 10;
  localparam int unsigned DEF_ADDR_W   = 32;
endpackage

// File: rtl/uft_regs.sv
module uft_regs
  import usb_frame_timer_pkg::*;
#(
  parameter int unsigned ADJ_W   = DEF_ADJ_W,
  parameter int unsigned ADJ_RST = DEF_ADJ_RST,
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned ALIGN_W = 12,
  localparam int unsigned BASE_W = ADDR_W - ALIGN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hc_rst_i,
  input  logic              we_i,
  input  reg_sel_e          sel_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADJ_W-1:0]  adj_o,
  output logic [BASE_W-1:0] base_o,
  output logic [ADDR_W-1:0] rdata_o
);
  logic [ADJ_W-1:0]  adj_q;
  logic [BASE_W-1:0] base_q;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adj_q  <= ADJ_W'(ADJ_RST);
      base_q <= '0;
    end else begin
      if (hc_rst_i)                    adj_q <= ADJ_W'(ADJ_RST);
      else if (we_i && sel_i == SEL_ADJ) adj_q <= wdata_i[ADJ_W-1:0];
      if (we_i && sel_i == SEL_BASE)   base_q <= wdata_i[ADDR_W-1:ALIGN_W];
    end
  end

  always_comb begin
    if (sel_i == SEL_BASE) rdata_o = {base_q, {ALIGN_W{1'b0}}};
    else                   rdata_o = ADDR_W'(adj_q);
  end

  assign adj_o  = adj_q;
  assign base_o = base_q;

  // R2
  adj_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_ADJ && !hc_rst_i) |=> adj_q == $past(wdata_i[ADJ_W-1:0]));
  // R5
  adj_hc_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hc_rst_i |=> adj_q == ADJ_W'(ADJ_RST));
  // R8
  base_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_BASE) |=> base_q == $past(wdata_i[ADDR_W-1:ALIGN_W]));
endmodule

// File: rtl/uft_cycle_cnt.sv
module uft_cycle_cnt
  import usb_frame_timer_pkg::*;
#(
  parameter int unsigned BASE_LEN = DEF_BASE_LEN,
  parameter int unsigned ADJ_W    = DEF_ADJ_W,
  parameter int unsigned ADJ_RST  = DEF_ADJ_RST,
  localparam int unsigned CNT_W   = $clog2(BASE_LEN + (1 << ADJ_W))
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hc_rst_i,
  input  logic             run_i,
  input  logic [ADJ_W-1:0] adj_i,
  output logic             sof_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [ADJ_W-1:0] act_q;
  logic [CNT_W-1:0] last_val;
  logic             last;

  assign last_val = CNT_W'(BASE_LEN) + CNT_W'(act_q) - CNT_W'(1);
  assign last     = (cnt_q == last_val);
  assign sof_o    = run_i && last;

  // Pending adjust is loaded only at a boundary or while idle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= ADJ_W'(ADJ_RST);
    end else if (hc_rst_i) begin
      cnt_q <= '0;
      act_q <= ADJ_W'(ADJ_RST);
    end else if (!run_i || last) begin
      cnt_q <= '0;
      act_q <= adj_i;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R3
  sof_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |=> !sof_o);
  // R4
  len_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !last && !hc_rst_i) |=> $stable(act_q));
  // R9
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/uft_index.sv
module uft_index #(
  parameter int unsigned FN_W   = 10,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned ALIGN_W = FN_W + 2,
  localparam int unsigned BASE_W  = ADDR_W - ALIGN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hc_rst_i,
  input  logic              sof_i,
  input  logic [BASE_W-1:0] base_i,
  output logic [FN_W-1:0]   fn_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [FN_W-1:0] fn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       fn_q <= '0;
    else if (hc_rst_i) fn_q <= '0;
    else if (sof_i)    fn_q <= fn_q + FN_W'(1);
  end

  assign fn_o   = fn_q;
  assign addr_o = {base_i, fn_q, 2'b00};

  // R6
  fn_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i && !hc_rst_i) |=> fn_q == $past(fn_q) + FN_W'(1));
  // R6
  fn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sof_i && !hc_rst_i) |=> $stable(fn_q));
  // R7
  addr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o[1:0] == 2'b00);
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
  import usb_frame_timer_pkg::*;
#(
  parameter int unsigned BASE_LEN = DEF_BASE_LEN,
  parameter int unsigned ADJ_W    = DEF_ADJ_W,
  parameter int unsigned ADJ_RST  = DEF_ADJ_RST,
  parameter int unsigned FN_W     = DEF_FN_W,
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  localparam int unsigned ALIGN_W = FN_W + 2,
  localparam int unsigned BASE_W  = ADDR_W - ALIGN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hc_rst_i,
  input  logic              run_i,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  output logic              sof_o,
  output logic [FN_W-1:0]   frame_num_o,
  output logic [ADDR_W-1:0] entry_addr_o
);
  logic [ADJ_W-1:0]  adj;
  logic [BASE_W-1:0] base;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(reg_sel_i);

  uft_regs #(
    .ADJ_W(ADJ_W), .ADJ_RST(ADJ_RST), .ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .hc_rst_i(hc_rst_i), .we_i(reg_we_i),
    .sel_i(sel), .wdata_i(reg_wdata_i), .adj_o(adj), .base_o(base),
    .rdata_o(reg_rdata_o)
  );

  uft_cycle_cnt #(
    .BASE_LEN(BASE_LEN), .ADJ_W(ADJ_W), .ADJ_RST(ADJ_RST)
  ) u_cycle (
    .clk_i(clk_i), .rst_ni(rst_ni), .hc_rst_i(hc_rst_i), .run_i(run_i),
    .adj_i(adj), .sof_o(sof_o)
  );

  uft_index #(
    .FN_W(FN_W), .ADDR_W(ADDR_W)
  ) u_index (
    .clk_i(clk_i), .rst_ni(rst_ni), .hc_rst_i(hc_rst_i), .sof_i(sof_o),
    .base_i(base), .fn_o(frame_num_o), .addr_o(entry_addr_o)
  );
endmodule

// File: tb/tb_usb_frame_timer.sv
`timescale 1ns/1ps
module tb_usb_frame_timer;
  localparam int BL = 20;

  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        hc_rst_i = 0, run_i = 0, reg_we_i = 0, reg_sel_i = 0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o, entry_addr_o;
  logic        sof_o;
  logic [9:0]  frame_num_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_cnt, m_act, m_adj, m_base, m_fn;
  bit wrap_seen = 0;
  int prev_fn = 0;

  always #4 clk_i = ~clk_i;

  usb_frame_timer #(.BASE_LEN(BL)) dut (.*);

  // behavioural reference, updated on the same edge as the design
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_act = 64; m_adj = 64; m_base = 0; m_fn = 0;
    end else begin
      if (hc_rst_i) begin
        m_cnt = 0; m_act = 64; m_adj = 64; m_fn = 0;
      end else begin
        if (run_i) begin
          if (m_cnt == BL + m_act - 1) begin
            m_cnt = 0; m_act = m_adj; m_fn = (m_fn + 1) % 1024;
          end else m_cnt++;
        end else begin
          m_cnt = 0; m_act = m_adj;
        end
        if (reg_we_i && !reg_sel_i) m_adj = reg_wdata_i & 32'h7f;
      end
      if (reg_we_i && reg_sel_i) m_base = reg_wdata_i >> 12;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    logic [31:0] e_rd, e_addr;
    logic e_sof;
    @(negedge clk_i);
    cyc++;
    e_sof  = run_i && (m_cnt == BL + m_act - 1);
    e_rd   = reg_sel_i ? (m_base << 12) : m_adj;
    e_addr = (m_base << 12) | (m_fn << 2);
    chk("R3 R4 R9 sof", {31'b0, sof_o}, {31'b0, e_sof});
    chk("R5 R6 frame number", {22'b0, frame_num_o}, m_fn);
    chk("R7 entry address", entry_addr_o, e_addr);
    chk("R1 R2 R8 readback", reg_rdata_o, e_rd);
    if (prev_fn == 1023 && frame_num_o == 0) wrap_seen = 1;
    prev_fn = frame_num_o;
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    reg_sel_i = sel; reg_wdata_i = d; reg_we_i = 1;
    step();
    reg_we_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 R8: reset state at the ports
    chk("R1 reset adjust", reg_rdata_o, 32'h40);
    reg_sel_i = 1; #1;
    chk("R8 reset base", reg_rdata_o, 32'h0);
    chk("R6 reset frame number", {22'b0, frame_num_o}, 0);
    reg_sel_i = 0;
    rst_ni = 1;
    // R9: idle, no strobe
    run_cycles(30);
    // R8: low 12 bits dropped
    wr(1, 32'hABCD_E123);
    step();
    chk("R8 base readback", reg_rdata_o, 32'hABCD_E000);
    // R3: default length frames
    reg_sel_i = 0;
    run_i = 1;
    run_cycles(200);
    // R4: change mid-frame
    wr(0, 32'h0000_0005);
    run_cycles(250);
    // R2: bit 7 and upper bits ignored
    wr(0, 32'hFFFF_FF8A);
    step();
    chk("R2 adjust readback", reg_rdata_o, 32'h0A);
    run_cycles(120);
    // R5: host-controller reset mid-run
    wr(0, 32'h0000_0011);
    run_cycles(13);
    hc_rst_i = 1; step(); hc_rst_i = 0;
    chk("R5 adjust after hc reset", reg_rdata_o, 32'h40);
    run_cycles(200);
    // R9: pause and resume
    run_i = 0;
    wr(0, 32'h0000_0002);
    run_cycles(10);
    run_i = 1;
    run_cycles(100);
    // R6: wrap at shortest frame
    wr(0, 32'h0);
    run_cycles(21500);
    chk("R6 wrap 1023->0 seen", {31'b0, wrap_seen}, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule